// File: doc/BRIEF.md
# Manchester Framed Serial Transmitter

This block turns a stream of payload bytes into one Manchester-coded serial line. Every frame has the same layout. A fixed synchronisation byte comes first. Then come the payload bytes in the order they were accepted. A fixed end byte closes the frame. The receiver uses the first byte to lock onto the bit phase and the last one to find the end of the frame without any side channel.

Bytes arrive on a valid/ready handshake that also carries a last-byte marker. A single holding register sits between the handshake and the bit shifter, so the next byte can be taken while the current one is still on the line. A half-bit tick generator sets the line timing. It divides the system clock down to a timebase tick (`TICK_DIV` clock cycles) and counts `HALF_TICKS` of those ticks per half-bit. With the defaults, one half-bit is 125 timebase ticks, which gives a 4000 bit/s line rate when the timebase runs at 1 MHz. A busy output covers the whole frame.

Top module: `manchester_frame_tx`

## Requirements
- R1: Out of reset and between frames, `tx_line` is low, `busy` is low and `in_ready` is high.
- R2: Each half-bit lasts exactly `TICK_DIV*HALF_TICKS` clock cycles. The tick counter restarts on the clock edge that accepts the first byte of a frame, so the first half-bit of the frame starts on that edge and has full length.
- R3: Bits leave most significant bit first. A 1 is sent as low then high (rising edge at mid-bit). A 0 is sent as high then low (falling edge at mid-bit).
- R4: Every frame starts with the byte 0xAA, so the synchronisation byte has no transitions at bit boundaries.
- R5: After the byte that carried the last marker, the byte 0xFF is sent as the end sentinel, and then the frame ends.
- R6: `in_ready` is low while a payload byte waits in the holding register, after a byte with the last marker has been accepted, and once the sentinel has been loaded. It stays low until the frame ends.
- R7: A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `busy` rises on the edge that accepts the first byte. `busy` falls, and `tx_line` returns low, on the edge that ends the sentinel's last half-bit.
- R8: If a byte boundary is reached with no byte waiting and no last marker seen, the sentinel is sent at once and the frame closes.
- R9: `tx_line` changes only at half-bit boundaries. A boundary transition appears only when two equal bits follow each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte on `in_data` is offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte is the final payload byte of the frame |
| in_ready | output | 1 | Block can take a payload byte this cycle |
| busy | output | 1 | A frame is being sent |
| tx_line | output | 1 | Manchester-coded serial output |

## Verification
The payload patterns each separate one class of fault:
- A single byte 0x3C exercises both mid-bit directions and both kinds of bit boundary (with and without a transition).
- A frame of 0x00, 0xFF and 0x5A separates errors in polarity and bit order. All-equal bits force a boundary transition on every bit; alternating bits force none.
- A byte sent without a last marker and never followed up exercises the underrun path to the sentinel.

Every frame is compared with the expected level on every clock cycle from the accepting edge onward, so a half-bit that is one cycle too long or too short shows up at once.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam logic [7:0]  SYNC_BYTE = 8'hAA;
    localparam logic [7:0]  END_BYTE  = 8'hFF;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_RUN  = 1'b1
    } fr_state_e;
endpackage

// File: rtl/mtx_half_tick.sv
module mtx_half_tick #(
    parameter int unsigned TICK_DIV   = 8,
    parameter int unsigned HALF_TICKS = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic half_tick
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int unsigned HW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [HW-1:0] half;
    } cnt_t;

    cnt_t c_q, c_d;
    logic pre_wrap, half_wrap;

    always_comb begin
        pre_wrap  = (c_q.pre == PW'(TICK_DIV - 1));
        half_wrap = (c_q.half == HW'(HALF_TICKS - 1));
        half_tick = pre_wrap & half_wrap;
        c_d = c_q;
        if (restart) begin
            c_d = '0;
        end else if (pre_wrap) begin
            c_d.pre  = '0;
            c_d.half = half_wrap ? '0 : c_q.half + HW'(1);
        end else begin
            c_d.pre = c_q.pre + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    generate
        if (TICK_DIV * HALF_TICKS > 1) begin : g_chk
            // R2: ticks are never back to back
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
                half_tick |=> !half_tick);
            // R2: a restart gives a full-length half-bit
            p_restart_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !half_tick);
        end
    endgenerate
endmodule

// File: rtl/mtx_line_shifter.sv
module mtx_line_shifter
    import mtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              start,
    input  logic              next_ok,
    input  logic [BYTE_W-1:0] next_byte,
    output logic              line,
    output logic              byte_end,
    output logic              active
);
    typedef struct packed {
        logic              active;
        logic [BYTE_W-1:0] sreg;
        logic [2:0]        idx;
        logic              second;
        logic              line;
    } sh_t;

    sh_t s_q, s_d;

    always_comb begin
        byte_end = s_q.active & half_tick & s_q.second & (s_q.idx == 3'd0);
        s_d = s_q;
        if (start) begin
            s_d.active = 1'b1;
            s_d.sreg   = SYNC_BYTE;
            s_d.idx    = 3'd7;
            s_d.second = 1'b0;
            s_d.line   = ~SYNC_BYTE[7];
        end else if (s_q.active && half_tick) begin
            if (!s_q.second) begin
                s_d.second = 1'b1;
                s_d.line   = s_q.sreg[s_q.idx];
            end else if (s_q.idx != 3'd0) begin
                s_d.idx    = s_q.idx - 3'd1;
                s_d.second = 1'b0;
                s_d.line   = ~s_q.sreg[s_q.idx - 3'd1];
            end else if (next_ok) begin
                s_d.sreg   = next_byte;
                s_d.idx    = 3'd7;
                s_d.second = 1'b0;
                s_d.line   = ~next_byte[7];
            end else begin
                s_d.active = 1'b0;
                s_d.second = 1'b0;
                s_d.line   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line   = s_q.line;
    assign active = s_q.active;

    // R9: the line moves only on a half-bit tick or a frame start
    p_line_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.line != s_d.line) |-> (half_tick || start));
    // R1: an idle shifter holds the line low
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> !s_q.line);
endmodule

// File: rtl/mtx_framer.sv
module mtx_framer
    import mtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              byte_end,
    output logic              in_ready,
    output logic              start,
    output logic              next_ok,
    output logic [BYTE_W-1:0] next_byte,
    output logic              busy
);
    typedef struct packed {
        fr_state_e         st;
        logic [BYTE_W-1:0] pend;
        logic              pend_full;
        logic              last_seen;
        logic              trail;
    } fr_t;

    fr_t f_q, f_d;
    logic accept;

    always_comb begin
        in_ready  = (f_q.st == FR_IDLE) |
                    (~f_q.pend_full & ~f_q.last_seen & ~f_q.trail & ~byte_end);
        accept    = in_valid & in_ready;
        start     = accept & (f_q.st == FR_IDLE);
        next_ok   = (f_q.st == FR_RUN) & (f_q.pend_full | ~f_q.trail);
        next_byte = f_q.pend_full ? f_q.pend : END_BYTE;
        f_d = f_q;
        if (start) begin
            f_d.st        = FR_RUN;
            f_d.pend      = in_data;
            f_d.pend_full = 1'b1;
            f_d.last_seen = in_last;
            f_d.trail     = 1'b0;
        end else if (f_q.st == FR_RUN) begin
            if (accept) begin
                f_d.pend      = in_data;
                f_d.pend_full = 1'b1;
                f_d.last_seen = in_last;
            end
            if (byte_end) begin
                if (f_q.pend_full) begin
                    f_d.pend_full = 1'b0;
                end else if (!f_q.trail) begin
                    f_d.trail = 1'b1;
                end else begin
                    f_d.st        = FR_IDLE;
                    f_d.last_seen = 1'b0;
                    f_d.trail     = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '{st: FR_IDLE, default: '0};
        else        f_q <= f_d;
    end

    assign busy = (f_q.st == FR_RUN);

    // R6: a taken byte occupies the holding slot, so ready drops next cycle
    p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    // R7: the frame ends only at the boundary of a byte
    p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(byte_end));
    // R7: a frame starts only through an accepted byte
    p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid && in_ready));
endmodule

// File: rtl/manchester_frame_tx.sv
module manchester_frame_tx
    import mtx_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 8,
    parameter int unsigned HALF_TICKS = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       busy,
    output logic       tx_line
);
    logic              half_tick;
    logic              start;
    logic              next_ok;
    logic [BYTE_W-1:0] next_byte;
    logic              byte_end;
    logic              sh_active;

    mtx_half_tick #(
        .TICK_DIV   (TICK_DIV),
        .HALF_TICKS (HALF_TICKS)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (start),
        .half_tick (half_tick)
    );

    mtx_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .byte_end  (byte_end),
        .in_ready  (in_ready),
        .start     (start),
        .next_ok   (next_ok),
        .next_byte (next_byte),
        .busy      (busy)
    );

    mtx_line_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .start     (start),
        .next_ok   (next_ok),
        .next_byte (next_byte),
        .line      (tx_line),
        .byte_end  (byte_end),
        .active    (sh_active)
    );

    // R7: shifter activity and frame busy agree
    p_active_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sh_active == busy);
endmodule

// File: tb/manchester_frame_tx_tb_top.sv
module manchester_frame_tx_tb_top;
    localparam int unsigned TD = 2;
    localparam int unsigned HT = 3;
    localparam int unsigned HB = TD * HT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready, busy, tx_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    manchester_frame_tx #(.TICK_DIV(TD), .HALF_TICKS(HT)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .busy     (busy),
        .tx_line  (tx_line)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // R3: MSB first, each bit as inverted level then true level
    task automatic push_byte(input logic [7:0] b, input string tag);
        for (int i = 7; i >= 0; i--) begin
            exp_q.push_back(~b[i]);
            tag_q.push_back(tag);
            exp_q.push_back(b[i]);
            tag_q.push_back(tag);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic l);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic monitor_frame();
        logic  e;
        string t;
        while (!busy) @(negedge clk);
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            for (int k = 0; k < int'(HB); k++) begin
                chk({t, " R2"}, "line level", int'(tx_line), int'(e));
                chk("R7", "busy in frame", int'(busy), 1);
                if (t == "R5" && k == 0) chk("R6", "ready during sentinel", int'(in_ready), 0);
                @(negedge clk);
            end
        end
        chk("R7", "busy after frame", int'(busy), 0);
        chk("R1", "line rests low", int'(tx_line), 0);
        chk("R1", "ready after frame", int'(in_ready), 1);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "reset line", int'(tx_line), 0);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle ready", int'(in_ready), 1);

        // Frame A: one byte with last marker (R4, R3, R5)
        push_byte(8'hAA, "R4");
        push_byte(8'h3C, "R3");
        push_byte(8'hFF, "R5");
        fork
            begin
                put_byte(8'h3C, 1'b1);
                chk("R6", "ready after last byte", int'(in_ready), 0);
            end
            monitor_frame();
        join
        repeat (3) @(negedge clk);

        // Frame B: all-zero, all-one and mixed payloads (R3, R9)
        push_byte(8'hAA, "R4");
        push_byte(8'h00, "R9");
        push_byte(8'hFF, "R3");
        push_byte(8'h5A, "R3");
        push_byte(8'hFF, "R5");
        fork
            begin
                put_byte(8'h00, 1'b0);
                chk("R6", "ready with byte held", int'(in_ready), 0);
                put_byte(8'hFF, 1'b0);
                put_byte(8'h5A, 1'b1);
            end
            monitor_frame();
        join
        repeat (5) @(negedge clk);

        // Frame C: underrun closes the frame with the sentinel (R8)
        push_byte(8'hAA, "R4");
        push_byte(8'h81, "R8");
        push_byte(8'hFF, "R5");
        fork
            put_byte(8'h81, 1'b0);
            monitor_frame();
        join
        repeat (2) @(negedge clk);

        // Frame D: back-to-back start after an underrun frame (R7)
        push_byte(8'hAA, "R4");
        push_byte(8'hC3, "R7");
        push_byte(8'hFF, "R5");
        fork
            put_byte(8'hC3, 1'b1);
            monitor_frame();
        join

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule